// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one block-transfer request into a stream of word addresses. A request carries a base address, a 16-bit mask naming the registers to move, an addressing mode and a writeback flag. Starting the cycle after the request, the sequencer produces one beat per clock for each selected register. Each beat carries a memory address and the index of the register it belongs to. The final beat is marked, and the updated base value is reported with it. The memory and the register file sit outside the block and only follow these beats.

There are four direct modes: increment or decrement, with the step taken either after or before each access. When the stack-alias input is set, a stack style and a pop/push select replace the direct mode. Whatever the direction, registers always land in ascending register-number order at ascending addresses. The direction and timing only decide where the window of addresses starts and which base value is written back.

The controller is a three-state machine. The states are `ST_IDLE` (waiting), `ST_XFER` (one beat per cycle) and `ST_EMPTY` (a single-cycle completion for an empty mask). It has these transitions:
- idle→xfer on a start with a non-empty mask
- idle→empty on a start with an empty mask
- xfer→xfer while more than one register is still pending
- xfer→idle on the last beat
- empty→idle unconditionally

Top module: `lsm_addr_seq`

## Requirements
- R1: While reset is held and after its release, busy, beat-valid, last, done and writeback-valid are all low.
- R2: With the stack-alias input low, `mode_i` selects the first address. 0 is increment-after and starts at base. 1 is increment-before and starts at base+4. 2 is decrement-after and starts at base−4·N+4. 3 is decrement-before and starts at base−4·N. N is the number of set mask bits.
- R3: Each beat's address is 4 above the previous one. Register indices are the set mask bits taken from lowest to highest, so the lowest index gets the lowest address.
- R4: `last_o` and `done_o` are high together on the final beat only, and done lasts exactly one cycle.
- R5: The reported new base is base+4·N for modes 0 and 1 and base−4·N for modes 2 and 3. `wb_valid_o` is high with done only when the writeback flag was set at start.
- R6: With `stack_en_i` high, `mode_i` is ignored and the mode comes from `stack_kind_i` and `pop_i` (1 = pop, 0 = push):
  - 0, full-descending: pop→0, push→3
  - 1, full-ascending: pop→2, push→1
  - 2, empty-descending: pop→1, push→2
  - 3, empty-ascending: pop→3, push→0
- R7: A start with an all-zero mask gives done (and writeback-valid if requested) in the next cycle with no beat, and the reported base equals the base.
- R8: A start raised while busy is ignored; the running sequence continues unchanged.
- R9: Every address has its two low bits zero; the two low bits of the base are treated as zero.
- R10: The first beat (or the empty-mask done) appears in the cycle after the accepted start. Busy stays high until the cycle carrying done and falls right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | ADDR_W | Base address |
| mask_i | input | NREG | Register selection mask |
| mode_i | input | 2 | Direct addressing mode |
| stack_en_i | input | 1 | Use the stack alias instead of mode_i |
| stack_kind_i | input | 2 | Stack style |
| pop_i | input | 1 | 1 = pop, 0 = push |
| wb_en_i | input | 1 | Request base writeback |
| busy_o | output | 1 | Sequence in progress |
| beat_valid_o | output | 1 | Address/index valid this cycle |
| addr_o | output | ADDR_W | Word address of this beat |
| reg_idx_o | output | $clog2(NREG) | Register index of this beat |
| last_o | output | 1 | Final beat |
| done_o | output | 1 | Completion pulse |
| wb_valid_o | output | 1 | Writeback value valid |
| wb_base_o | output | ADDR_W | Updated base value |

## Verification
The four direct modes are driven with the same three-register mask and bases, so only the window start and writeback sign set them apart. The full mask exposes the width of the span, and a wrap-around below zero checks modular arithmetic. All eight stack aliases use one base with a contradicting direct mode, which shows the alias really overrides it. An empty mask, an unaligned base and a start pulsed mid-sequence separate the completion path, the alignment rule and the input gating.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        STK_FULL_DESC  = 2'd0,
        STK_FULL_ASC   = 2'd1,
        STK_EMPTY_DESC = 2'd2,
        STK_EMPTY_ASC  = 2'd3
    } stack_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_EMPTY = 2'd2
    } seq_state_e;
endpackage

// File: rtl/lsm_mode_map.sv
module lsm_mode_map
    import lsm_pkg::*;
(
    input  logic       stack_en_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] stack_kind_i,
    input  logic       pop_i,
    output addr_mode_e eff_mode_o
);
    addr_mode_e stk_mode;

    always_comb begin
        unique case (stack_kind_e'(stack_kind_i))
            STK_FULL_DESC:  stk_mode = pop_i ? AM_INC_AFTER  : AM_DEC_BEFORE;
            STK_FULL_ASC:   stk_mode = pop_i ? AM_DEC_AFTER  : AM_INC_BEFORE;
            STK_EMPTY_DESC: stk_mode = pop_i ? AM_INC_BEFORE : AM_DEC_AFTER;
            STK_EMPTY_ASC:  stk_mode = pop_i ? AM_DEC_BEFORE : AM_INC_AFTER;
        endcase
    end

    assign eff_mode_o = stack_en_i ? stk_mode : addr_mode_e'(mode_i);
endmodule

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/lsm_low_pick.sv
module lsm_low_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          single_o
);
    logic [N-1:0] below;

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign below    = vec_i & (vec_i - N'(1));
    assign single_o = (vec_i != '0) && (below == '0);
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       base_i,
    input  logic [NREG-1:0]         mask_i,
    input  logic [1:0]              mode_i,
    input  logic                    stack_en_i,
    input  logic [1:0]              stack_kind_i,
    input  logic                    pop_i,
    input  logic                    wb_en_i,
    output logic                    busy_o,
    output logic                    beat_valid_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [$clog2(NREG)-1:0] reg_idx_o,
    output logic                    last_o,
    output logic                    done_o,
    output logic                    wb_valid_o,
    output logic [ADDR_W-1:0]       wb_base_o
);
    localparam int CNT_W = $clog2(NREG + 1);
    localparam int IDX_W = $clog2(NREG);
    localparam int PAD_W = ADDR_W - CNT_W - 2;
    localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

    seq_state_e          state_q, state_d;
    addr_mode_e          eff_mode;
    logic [CNT_W-1:0]    sel_cnt;
    logic [ADDR_W-1:0]   base_al, span, first_addr, new_base;
    logic [ADDR_W-1:0]   addr_q, wb_base_q;
    logic [NREG-1:0]     remain_q;
    logic                wb_en_q;
    logic [IDX_W-1:0]    pick_idx;
    logic                pick_single;
    logic                accept;

    lsm_mode_map u_map (
        .stack_en_i   (stack_en_i),
        .mode_i       (mode_i),
        .stack_kind_i (stack_kind_i),
        .pop_i        (pop_i),
        .eff_mode_o   (eff_mode)
    );

    lsm_popcount #(.N(NREG), .CW(CNT_W)) u_pop (
        .vec_i   (mask_i),
        .count_o (sel_cnt)
    );

    lsm_low_pick #(.N(NREG), .IW(IDX_W)) u_pick (
        .vec_i    (remain_q),
        .idx_o    (pick_idx),
        .single_o (pick_single)
    );

    assign base_al = {base_i[ADDR_W-1:2], 2'b00};
    assign span    = {{PAD_W{1'b0}}, sel_cnt, 2'b00};
    assign accept  = (state_q == ST_IDLE) && start_i;

    always_comb begin
        unique case (eff_mode)
            AM_INC_AFTER:  first_addr = base_al;
            AM_INC_BEFORE: first_addr = base_al + WORD;
            AM_DEC_AFTER:  first_addr = base_al - span + WORD;
            AM_DEC_BEFORE: first_addr = base_al - span;
        endcase
        new_base = eff_mode[1] ? (base_al - span) : (base_al + span);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (mask_i == '0) ? ST_EMPTY : ST_XFER;
            ST_XFER:  if (pick_single) state_d = ST_IDLE;
            ST_EMPTY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sequence datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            remain_q  <= '0;
            wb_base_q <= '0;
            wb_en_q   <= 1'b0;
        end else if (accept) begin
            addr_q    <= first_addr;
            remain_q  <= mask_i;
            wb_base_q <= new_base;
            wb_en_q   <= wb_en_i;
        end else if (state_q == ST_XFER) begin
            addr_q    <= addr_q + WORD;
            remain_q  <= remain_q & (remain_q - NREG'(1));
        end
    end

    // outputs
    always_comb begin
        busy_o       = 1'b0;
        beat_valid_o = 1'b0;
        last_o       = 1'b0;
        done_o       = 1'b0;
        wb_valid_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy_o       = 1'b1;
                beat_valid_o = 1'b1;
                last_o       = pick_single;
                done_o       = pick_single;
                wb_valid_o   = pick_single && wb_en_q;
            end
            ST_EMPTY: begin
                busy_o     = 1'b1;
                done_o     = 1'b1;
                wb_valid_o = wb_en_q;
            end
            default: ;
        endcase
    end

    assign addr_o    = addr_q;
    assign reg_idx_o = pick_idx;
    assign wb_base_o = wb_base_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    busy_o,
    input logic                    beat_valid_o,
    input logic [ADDR_W-1:0]       addr_o,
    input logic [$clog2(NREG)-1:0] reg_idx_o,
    input logic                    last_o,
    input logic                    done_o,
    input logic                    wb_valid_o
);
    assert_word_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> addr_o[1:0] == 2'b00);

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o) && !$past(last_o)) |-> addr_o == $past(addr_o) + ADDR_W'(4));

    assert_idx_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o) && !$past(last_o)) |-> reg_idx_o > $past(reg_idx_o));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && last_o) |-> done_o);

    assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !last_o) |=> beat_valid_o);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .beat_valid_o (beat_valid_o),
    .addr_o       (addr_o),
    .reg_idx_o    (reg_idx_o),
    .last_o       (last_o),
    .done_o       (done_o),
    .wb_valid_o   (wb_valid_o)
);

// File: tb/lsm_addr_seq_tb.sv
module lsm_addr_seq_tb;
    localparam int NB = 16;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] mask;
        logic [1:0]  mode;
        logic        stk;
        logic [1:0]  kind;
        logic        pop;
        logic        wb;
        logic [31:0] exp_first;
        logic [31:0] exp_wb;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{32'h10,   16'h000E, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h10,       32'h1C},
        '{32'h10,   16'h000E, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 32'h14,       32'h1C},
        '{32'h24,   16'h000E, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1C,       32'h18},
        '{32'h24,   16'h000E, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 32'h18,       32'h18},
        '{32'h1000, 16'hFFFF, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1000,     32'h1040},
        '{32'h1000, 16'hFFFF, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 32'h0FC0,     32'h0FC0},
        '{32'h200,  16'h8001, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 32'h1FC,      32'h1F8},
        '{32'h0,    16'h0001, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 32'hFFFFFFFC, 32'hFFFFFFFC},
        '{32'h80,   16'h0100, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h84,       32'h84},
        '{32'h40,   16'h0003, 2'd3, 1'b1, 2'd0, 1'b1, 1'b1, 32'h40,       32'h48},
        '{32'h40,   16'h0003, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 32'h38,       32'h38},
        '{32'h40,   16'h0003, 2'd3, 1'b1, 2'd1, 1'b1, 1'b1, 32'h3C,       32'h38},
        '{32'h40,   16'h0003, 2'd3, 1'b1, 2'd1, 1'b0, 1'b1, 32'h44,       32'h48},
        '{32'h40,   16'h0003, 2'd3, 1'b1, 2'd2, 1'b1, 1'b1, 32'h44,       32'h48},
        '{32'h40,   16'h0003, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h3C,       32'h38},
        '{32'h40,   16'h0003, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 32'h38,       32'h38},
        '{32'h40,   16'h0003, 2'd3, 1'b1, 2'd3, 1'b0, 1'b1, 32'h40,       32'h48}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  mode_i = '0;
    logic        stack_en_i = 1'b0;
    logic [1:0]  stack_kind_i = '0;
    logic        pop_i = 1'b0;
    logic        wb_en_i = 1'b0;
    logic        busy_o, beat_valid_o, last_o, done_o, wb_valid_o;
    logic [31:0] addr_o, wb_base_o;
    logic [3:0]  reg_idx_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lsm_addr_seq #(.ADDR_W(32), .NREG(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .mask_i(mask_i), .mode_i(mode_i), .stack_en_i(stack_en_i),
        .stack_kind_i(stack_kind_i), .pop_i(pop_i), .wb_en_i(wb_en_i),
        .busy_o(busy_o), .beat_valid_o(beat_valid_o), .addr_o(addr_o),
        .reg_idx_o(reg_idx_o), .last_o(last_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke, input string tag);
        int n = 0;
        int k = 0;
        for (int i = 0; i < NB; i++) if (v.mask[i]) n++;
        @(negedge clk);
        base_i = v.base; mask_i = v.mask; mode_i = v.mode; stack_en_i = v.stk;
        stack_kind_i = v.kind; pop_i = v.pop; wb_en_i = v.wb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (v.mask[i]) begin
                chk(beat_valid_o && busy_o, {tag, " R10 beat present"}, 32'(beat_valid_o), 32'd1);
                chk(addr_o == v.exp_first + 32'(4 * k), {tag, " R3 address"}, addr_o, v.exp_first + 32'(4 * k));
                chk(reg_idx_o == 4'(i), {tag, " R3 register index"}, 32'(reg_idx_o), 32'(i));
                chk(last_o == (k == n - 1) && done_o == (k == n - 1), {tag, " R4 last/done"},
                    32'({last_o, done_o}), (k == n - 1) ? 32'd3 : 32'd0);
                if (k == n - 1) begin
                    chk(wb_valid_o == v.wb, {tag, " R5 wb valid"}, 32'(wb_valid_o), 32'(v.wb));
                    chk(wb_base_o == v.exp_wb, {tag, " R5 wb base"}, wb_base_o, v.exp_wb);
                end
                start_i = poke && (k == 1);
                if (start_i) begin
                    base_i = 32'hDEAD0000; mask_i = 16'h0001; mode_i = 2'd3;
                end
                k++;
                @(negedge clk);
            end
        end
        start_i = 1'b0;
        chk(!busy_o && !done_o && !beat_valid_o, {tag, " R10 idle after done"},
            32'({busy_o, done_o, beat_valid_o}), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !beat_valid_o && !last_o && !wb_valid_o, "R1 in reset",
            32'({busy_o, done_o, beat_valid_o, last_o, wb_valid_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !beat_valid_o && !last_o && !wb_valid_o, "R1 after reset",
            32'({busy_o, done_o, beat_valid_o, last_o, wb_valid_o}), 32'd0);

        for (int j = 0; j < NV; j++) begin
            run_vec(VEC[j], 1'b0, VEC[j].stk ? "R6" : "R2");
        end

        // R8: start pulsed during a running full-mask sequence
        run_vec(VEC[4], 1'b1, "R8");

        // R9: unaligned base, low bits dropped
        run_vec('{32'h13, 16'h0004, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h10, 32'h14}, 1'b0, "R9");

        // R7: empty mask
        @(negedge clk);
        base_i = 32'h500; mask_i = '0; mode_i = 2'd0; stack_en_i = 1'b0; wb_en_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && busy_o && !beat_valid_o && wb_valid_o, "R7 empty done",
            32'({done_o, busy_o, beat_valid_o, wb_valid_o}), 32'hD);
        chk(wb_base_o == 32'h500, "R7 base unchanged", wb_base_o, 32'h500);
        @(negedge clk);
        chk(!done_o && !busy_o, "R7 done single cycle", 32'({done_o, busy_o}), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule